// File: doc/BRIEF.md
# Phase-Checked Dual-Rail Lookup Cell

This block is a two-input lookup-table cell for a fabric whose signals travel as level-encoded dual-rail pairs. Each input is a value rail paired with a repeat rail. The value is the value rail itself. The phase is the XOR of the two rails. Successive tokens on a wire alternate phase, and no spacer token separates them. Each new token therefore costs exactly one rail transition.

On every clock edge the cell decodes all inputs and compares their phases. If every input carries the same phase and that phase is the one the cell expects next, the cell does three things. It selects one of four configuration bits, addressed by the input values. It stores that bit in its output pair, encoded in the new phase. It pulses a done flag. A mix of phases is an incomplete token set and selects nothing. A set that repeats the phase already consumed also selects nothing. In both cases the output rails keep their state. The four configuration bits load through a synchronous write port.

Top module: `ledr_lut_cell`

## Requirements
- R1: While reset is held and on its release, both output rails and done are 0 (the phase-0 code for value 0), and the cell expects phase 1 next.
- R2: An input's value is its value rail, and its phase is value rail XOR repeat rail. After an evaluation, out_v XOR out_r equals the common input phase.
- R3: If the input phases differ, no entry is selected: out_v and out_r keep their values and done stays 0 in the following cycle.
- R4: When all input phases agree with the expected phase, out_v becomes cfg bit number {in_v[1], in_v[0]}, with input 0 as the address LSB.
- R5: Done is 1 for the cycle after an accepted evaluation only. The same phase presented again gives no done, and neither output rail toggles.
- R6: Each accepted evaluation changes exactly one output rail.
- R7: A configuration write (cfg_we=1) takes effect from the next evaluation onward. An evaluation in the same cycle as the write uses the old bits. The configuration bits reset to 0.
- R8: After reset, inputs in phase 0 (for example all rails 0) are not evaluated. The first accepted token is a phase-1 token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_v | input | 2 | Value rail of each input |
| in_r | input | 2 | Repeat rail of each input |
| cfg_we | input | 1 | Configuration write enable |
| cfg_bits | input | 4 | Truth-table bits, bit k is the result for address k |
| out_v | output | 1 | Output value rail |
| out_r | output | 1 | Output repeat rail |
| done | output | 1 | One-cycle pulse after an evaluation |

## Verification
The assertions assume that the input rails are steady at each sampling edge. They also assume that a single edge never sees a partly updated token as a same-phase set with a wrong value. Any same-phase set is taken as complete.

The bench changes its inputs only at falling edges, one whole token or one deliberate phase mix at a time. Every token it presents is built from a value and a chosen phase. The bench sweeps all sixteen tables against all four addresses. It also covers repeated tokens, mixed phases, and writes that coincide with an evaluation.

// File: rtl/ledr_lut_pkg.sv
package ledr_lut_pkg;
  localparam int unsigned N_IN = 2;
  localparam int unsigned TBL  = 1 << N_IN;

  typedef struct packed {
    logic val;
    logic ph;
  } ledr_sym_t;

  function automatic logic ledr_phase(input logic v, input logic r);
    return v ^ r;
  endfunction

  function automatic logic ledr_rep(input logic v, input logic ph);
    return v ^ ph;
  endfunction
endpackage

// File: rtl/ledr_decode.sv
module ledr_decode
  import ledr_lut_pkg::*;
#(
  parameter int unsigned W = N_IN
) (
  input  logic [W-1:0] v_i,
  input  logic [W-1:0] r_i,
  output logic [W-1:0] val_o,
  output logic [W-1:0] ph_o
);
  for (genvar g = 0; g < W; g++) begin : g_lane
    ledr_sym_t sym;
    always_comb begin
      sym.val  = v_i[g];
      sym.ph   = ledr_phase(v_i[g], r_i[g]);
      val_o[g] = sym.val;
      ph_o[g]  = sym.ph;
    end
  end
endmodule

// File: rtl/ledr_phase_gate.sv
module ledr_phase_gate
  import ledr_lut_pkg::*;
#(
  parameter int unsigned W = N_IN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ph_i,
  output logic         fire_o,
  output logic         ph_o
);
  logic exp_q, exp_d;
  logic all_one, all_zero, agree;

  always_comb begin
    all_one  = &ph_i;
    all_zero = ~|ph_i;
    agree    = all_one | all_zero;
    ph_o     = all_one;
    fire_o   = agree && (ph_o == exp_q);
    exp_d    = exp_q;
    if (fire_o) exp_d = ~exp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_q <= 1'b1;
    else        exp_q <= exp_d;
  end

  // R8: no evaluation can occur before the first phase-1 token
  p_first_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && exp_q) |-> (&ph_i));
endmodule

// File: rtl/ledr_lut_table.sv
module ledr_lut_table
  import ledr_lut_pkg::*;
#(
  parameter int unsigned W = N_IN,
  localparam int unsigned D = 1 << W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [D-1:0] wdata_i,
  input  logic         fire_i,
  input  logic [W-1:0] val_i,
  output logic         bit_o
);
  logic [D-1:0] cfg_q, cfg_d;
  logic [D-1:0] sel;

  for (genvar k = 0; k < D; k++) begin : g_entry
    localparam logic [W-1:0] KEY = W'(k);
    always_comb sel[k] = fire_i & (&(val_i ~^ KEY));
  end

  always_comb begin
    bit_o = |(sel & cfg_q);
    cfg_d = cfg_q;
    if (we_i) cfg_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  p_sel_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> ($countones(sel) == 1));
endmodule

// File: rtl/ledr_lut_cell.sv
module ledr_lut_cell
  import ledr_lut_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] in_v,
  input  logic [N_IN-1:0] in_r,
  input  logic            cfg_we,
  input  logic [TBL-1:0]  cfg_bits,
  output logic            out_v,
  output logic            out_r,
  output logic            done
);
  logic [N_IN-1:0] val, ph;
  logic fire, cur_ph, sel_bit;
  logic ov_q, ov_d, or_q, or_d, dn_q, dn_d;

  ledr_decode #(.W(N_IN)) u_dec (
    .v_i(in_v), .r_i(in_r), .val_o(val), .ph_o(ph));

  ledr_phase_gate #(.W(N_IN)) u_gate (
    .clk(clk), .rst_n(rst_n), .ph_i(ph), .fire_o(fire), .ph_o(cur_ph));

  ledr_lut_table #(.W(N_IN)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_bits),
    .fire_i(fire), .val_i(val), .bit_o(sel_bit));

  always_comb begin
    ov_d = ov_q;
    or_d = or_q;
    dn_d = 1'b0;
    if (fire) begin
      ov_d = sel_bit;
      or_d = ledr_rep(sel_bit, cur_ph);
      dn_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      or_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      ov_q <= ov_d;
      or_q <= or_d;
      dn_q <= dn_d;
    end
  end

  assign out_v = ov_q;
  assign out_r = or_q;
  assign done  = dn_q;

  p_one_rail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({out_v ^ $past(out_v), out_r ^ $past(out_r)}) == 1));
  p_out_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((out_v ^ out_r) == ($past(in_v[0]) ^ $past(in_r[0]))));
  p_mixed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != '0 && ph != '1) |=> !done);
  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(out_v) && $stable(out_r)));
endmodule

// File: tb/ledr_lut_cell_bench.sv
`timescale 1ns/1ps
module ledr_lut_cell_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] in_v, in_r;
  logic cfg_we;
  logic [3:0] cfg_bits;
  logic out_v, out_r, done;

  int n_run = 0;
  int n_fail = 0;

  logic m_ph, m_v, m_r;
  logic [3:0] m_cfg;

  always #2.5 clk = ~clk;

  ledr_lut_cell u_ledr_lut_cell (
    .clk(clk), .rst_n(rst_n), .in_v(in_v), .in_r(in_r),
    .cfg_we(cfg_we), .cfg_bits(cfg_bits),
    .out_v(out_v), .out_r(out_r), .done(done));

  task automatic check(input string tag, input logic ev, input logic er, input logic ed);
    n_run++;
    if (out_v !== ev || out_r !== er || done !== ed) begin
      n_fail++;
      $display("FAIL %s: got v=%b r=%b done=%b, expected v=%b r=%b done=%b",
               tag, out_v, out_r, done, ev, er, ed);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] vv, input logic [1:0] rr,
                      input logic we, input logic [3:0] wc);
    logic fire, d;
    @(negedge clk);
    in_v = vv; in_r = rr; cfg_we = we; cfg_bits = wc;
    fire = ((vv[0] ^ rr[0]) == (vv[1] ^ rr[1])) && ((vv[0] ^ rr[0]) == m_ph);
    d = 1'b0;
    if (fire) begin
      m_v = m_cfg[vv];
      m_r = m_v ^ m_ph;
      m_ph = ~m_ph;
      d = 1'b1;
    end
    if (we) m_cfg = wc;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    check(tag, m_v, m_r, d);
  endtask

  function automatic logic [1:0] rep_of(input logic [1:0] a, input logic ph);
    return a ^ {ph, ph};
  endfunction

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] hv, hr;
    rst_n = 1'b0; in_v = '0; in_r = '0; cfg_we = 1'b0; cfg_bits = '0;
    m_ph = 1'b1; m_v = 1'b0; m_r = 1'b0; m_cfg = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 1'b0, 1'b0, 1'b0);
    // R8: phase-0 all-zero token is not evaluated after reset
    step("R8 phase0 ignored", 2'b00, 2'b00, 1'b0, 4'h0);
    step("R8 phase0 other value", 2'b11, 2'b11, 1'b0, 4'h0);
    hv = 2'b11; hr = 2'b11;
    for (int c = 0; c < 16; c++) begin
      // R7: write while inputs repeat the consumed phase
      step("R7 write idle", hv, hr, 1'b1, 4'(c));
      for (int a = 0; a < 4; a++) begin
        logic cp;
        cp = m_ph;
        step("R4 lookup", 2'(a), rep_of(2'(a), cp), 1'b0, 4'h0);
        step("R5 repeat no toggle", 2'(a), rep_of(2'(a), cp), 1'b0, 4'h0);
        step("R2 phase other value held", 2'(3 - a), rep_of(2'(3 - a), cp), 1'b0, 4'h0);
        step("R3 mixed phase", 2'(a), 2'(a) ^ {~m_ph, m_ph}, 1'b0, 4'h0);
        step("R3 mixed phase swap", 2'(a), 2'(a) ^ {m_ph, ~m_ph}, 1'b0, 4'h0);
        hv = 2'(a); hr = rep_of(2'(a), cp);
      end
      // R7: write coinciding with an evaluation uses the old table
      step("R7 same-cycle write", 2'b10, rep_of(2'b10, m_ph), 1'b1, ~4'(c));
      step("R7 new table used", 2'b10, rep_of(2'b10, m_ph), 1'b0, 4'h0);
      hv = 2'b10; hr = rep_of(2'b10, ~m_ph);
    end
    // R6: alternate tokens every cycle
    for (int k = 0; k < 8; k++)
      step("R6 back-to-back", 2'(k), rep_of(2'(k), m_ph), 1'b0, 4'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule